// File: doc/BRIEF.md
# Memory Fill Engine

The block writes one 64-bit pattern over and over into a region of memory. Software places a destination base address, a region length in bytes and the two 32-bit halves of the pattern on configuration inputs, selects the fill operation in a 2-bit mode field, and pulses a start strobe. The engine captures everything it needs at launch. It then issues one 64-bit write per accepted beat on a valid/ready memory port, moving the address forward by 8 bytes per beat, and reports busy for the whole run.

The length is checked before any write goes out. A region that is too short, too long or not a whole number of beats raises an error flag and leaves the engine idle. A start that arrives while a run is in progress is ignored. A stop strobe ends a run early. It waits until the beat currently offered has been taken, so the valid/ready rules are never broken. When the last beat of a region is accepted, the engine drops busy and pulses done for one cycle.

Top module: `memfill_engine`

## Requirements
- R1: After reset, busy, wr_valid, done and size_err are all 0.
- R2: A start pulse seen while idle, with cfg_mode equal to 2'b01 (fill) and a legal length, makes busy and wr_valid 1 in the next cycle, with wr_addr equal to dst_base.
- R3: Each beat carries wr_data = {pat_hi, pat_lo} as captured at launch. Each accepted beat moves wr_addr up by 8. A full run issues exactly fill_len/8 beats.
- R4: While wr_valid is 1 and wr_ready is 0, wr_valid stays 1 and wr_addr and wr_data hold their values.
- R5: A length is legal when it is at least 128, at most 16777216 and a multiple of 8. A fill start with an illegal length sets size_err, issues no write and leaves busy at 0. The next accepted launch clears size_err.
- R6: A start pulse while busy is ignored. The run keeps its address sequence and pattern, and size_err does not change.
- R7: A start pulse with cfg_mode other than 2'b01 has no effect: busy stays 0 and size_err keeps its value.
- R8: Busy falls in the cycle after the last beat is accepted. Done is 1 for exactly that one cycle, and done is never 1 while busy.
- R9: A stop pulse during a run ends it once the beat on offer is accepted, with no done pulse. If the beat is accepted in the same cycle as the stop, the run ends at once. A stop while idle has no effect.
- R10: When a stop coincides with acceptance of the last beat, the region counts as complete and done still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Operation select; 2'b01 is fill |
| start | input | 1 | Launch strobe |
| stop | input | 1 | Abort strobe |
| dst_base | input | 32 | Destination start address |
| fill_len | input | 25 | Region length in bytes |
| pat_hi | input | 32 | Upper half of fill pattern |
| pat_lo | input | 32 | Lower half of fill pattern |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 64 | Write data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse on region completion |
| size_err | output | 1 | Last fill launch was refused for its length |

## Verification
The run can end for two reasons: the last beat is accepted, or a stop arrives. These can land on the same clock edge. The bench raises stop so that it is sampled together with the handshake of the sixteenth and final beat of a 128-byte region. It expects done to pulse and the beat count to be exactly 16. A second clash is a start strobe arriving on the same edge as a mid-run handshake, with new base, pattern and an illegal length on the inputs. There the scoreboard must still see the original sequence, and size_err must stay low.

// File: rtl/memfill_pkg.sv
package memfill_pkg;

    // Operation select code that runs the fill engine.
    localparam logic [1:0] OP_FILL = 2'b01;

endpackage

// File: rtl/memfill_size_check.sv
module memfill_size_check #(
    parameter int SIZE_W     = 25,
    parameter int MIN_BYTES  = 128,
    parameter int MAX_BYTES  = 16777216,
    parameter int BEAT_BYTES = 8
) (
    input  logic [SIZE_W-1:0] len,
    output logic              ok
);
    localparam logic [SIZE_W-1:0] LO_LIM = SIZE_W'(MIN_BYTES);
    localparam logic [SIZE_W-1:0] HI_LIM = SIZE_W'(MAX_BYTES);
    localparam logic [SIZE_W-1:0] ALIGN  = SIZE_W'(BEAT_BYTES - 1);

    always_comb begin
        ok = (len >= LO_LIM) && (len <= HI_LIM) && ((len & ALIGN) == '0);
    end
endmodule

// File: rtl/memfill_launch_gate.sv
module memfill_launch_gate
    import memfill_pkg::*;
(
    input  logic       running,
    input  logic       start,
    input  logic [1:0] mode,
    input  logic       len_ok,
    output logic       launch,
    output logic       refuse
);
    logic eligible;

    always_comb begin
        eligible = start && !running && (mode == OP_FILL);
        launch   = eligible && len_ok;
        refuse   = eligible && !len_ok;
    end
endmodule

// File: rtl/memfill_engine.sv
module memfill_engine #(
    parameter int ADDR_W    = 32,
    parameter int HALF_W    = 32,
    parameter int SIZE_W    = 25,
    parameter int MIN_BYTES = 128,
    parameter int MAX_BYTES = 16777216
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cfg_mode,
    input  logic                start,
    input  logic                stop,
    input  logic [ADDR_W-1:0]   dst_base,
    input  logic [SIZE_W-1:0]   fill_len,
    input  logic [HALF_W-1:0]   pat_hi,
    input  logic [HALF_W-1:0]   pat_lo,
    output logic                wr_valid,
    input  logic                wr_ready,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [2*HALF_W-1:0] wr_data,
    output logic                busy,
    output logic                done,
    output logic                size_err
);
    localparam int DATA_W     = 2 * HALF_W;
    localparam int BEAT_BYTES = DATA_W / 8;
    localparam int STEP_SH    = $clog2(BEAT_BYTES);
    localparam int CNT_W      = SIZE_W - STEP_SH;

    typedef struct packed {
        logic              busy;
        logic              stop_pend;
        logic              done;
        logic              err;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  left;
        logic [DATA_W-1:0] pat;
    } fill_state_t;

    fill_state_t st_q, st_d;

    logic len_ok;
    logic launch;
    logic refuse;
    logic fire;
    logic last_beat;

    memfill_size_check #(
        .SIZE_W    (SIZE_W),
        .MIN_BYTES (MIN_BYTES),
        .MAX_BYTES (MAX_BYTES),
        .BEAT_BYTES(BEAT_BYTES)
    ) u_size_check (
        .len (fill_len),
        .ok  (len_ok)
    );

    memfill_launch_gate u_launch_gate (
        .running (st_q.busy),
        .start   (start),
        .mode    (cfg_mode),
        .len_ok  (len_ok),
        .launch  (launch),
        .refuse  (refuse)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        fire      = st_q.busy && wr_ready;
        last_beat = (st_q.left == CNT_W'(1));

        if (!st_q.busy) begin
            if (launch) begin
                st_d.busy      = 1'b1;
                st_d.stop_pend = 1'b0;
                st_d.err       = 1'b0;
                st_d.addr      = dst_base;
                st_d.left      = fill_len[SIZE_W-1:STEP_SH];
                st_d.pat       = {pat_hi, pat_lo};
            end else if (refuse) begin
                st_d.err = 1'b1;
            end
        end else if (fire) begin
            st_d.addr = st_q.addr + ADDR_W'(BEAT_BYTES);
            st_d.left = st_q.left - CNT_W'(1);
            if (last_beat) begin
                // Completion takes priority over a coincident stop.
                st_d.busy      = 1'b0;
                st_d.stop_pend = 1'b0;
                st_d.done      = 1'b1;
            end else if (stop || st_q.stop_pend) begin
                st_d.busy      = 1'b0;
                st_d.stop_pend = 1'b0;
            end
        end else if (stop) begin
            // Beat still on offer: finish it before leaving.
            st_d.stop_pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        wr_valid = st_q.busy;
        wr_addr  = st_q.addr;
        wr_data  = st_q.pat;
        busy     = st_q.busy;
        done     = st_q.done;
        size_err = st_q.err;
    end
endmodule

// File: rtl/memfill_checker.sv
module memfill_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              stop,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              busy,
    input logic              done,
    input logic              size_err
);
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> (!wr_valid || (wr_addr == $past(wr_addr) + ADDR_W'(8))));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !wr_valid));

    p_err_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(size_err) |-> $past(!busy));

    p_refuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> !$rose(size_err));

    p_stop_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && stop && wr_ready) |=> !busy);
endmodule

bind memfill_engine memfill_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (2 * HALF_W)
) u_memfill_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .stop     (stop),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .busy     (busy),
    .done     (done),
    .size_err (size_err)
);

// File: tb/memfill_engine_bench.sv
module memfill_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'b00;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic [31:0] dst_base = '0;
    logic [24:0] fill_len = '0;
    logic [31:0] pat_hi = '0;
    logic [31:0] pat_lo = '0;
    logic        wr_valid;
    logic        wr_ready;
    logic [31:0] wr_addr;
    logic [63:0] wr_data;
    logic        busy;
    logic        done;
    logic        size_err;

    logic        auto_rdy = 1'b0;
    logic        man_rdy = 1'b0;
    logic        rdy_pat = 1'b1;
    logic [7:0]  lfsr = 8'hA5;

    int vectors = 0;
    int fails = 0;
    int beats = 0;
    int dones = 0;
    logic [95:0] exp_q[$];

    always #2 clk = ~clk;

    assign wr_ready = auto_rdy ? rdy_pat : man_rdy;

    memfill_engine u_memfill_engine (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .start(start), .stop(stop),
        .dst_base(dst_base), .fill_len(fill_len), .pat_hi(pat_hi), .pat_lo(pat_lo),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done), .size_err(size_err)
    );

    always @(posedge clk) begin
        #1;
        lfsr    <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        rdy_pat <= lfsr[0] | lfsr[2];
    end

    // Monitor: pops expected beats and compares (R3).
    always @(negedge clk) begin
        if (rst_n && wr_valid && wr_ready) begin
            beats++;
            vectors++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R3 unexpected beat: act addr %h data %h, exp none", wr_addr, wr_data);
            end else begin
                logic [95:0] e;
                e = exp_q.pop_front();
                if ({wr_addr, wr_data} !== e) begin
                    fails++;
                    $display("FAIL R3 beat: act %h_%h, exp %h_%h", wr_addr, wr_data, e[95:64], e[63:0]);
                end
            end
        end
        if (rst_n && done) dones++;
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act %h, exp %h", req, act, exp);
        end
    endtask

    task automatic setup(input logic [31:0] b, input logic [24:0] l,
                         input logic [31:0] h, input logic [31:0] lo, input int max_push);
        int n;
        dst_base = b; fill_len = l; pat_hi = h; pat_lo = lo;
        n = int'(l) / 8;
        if (n > max_push) n = max_push;
        for (int i = 0; i < n; i++) exp_q.push_back({b + 32'(8 * i), h, lo});
    endtask

    task automatic pulse_start(input logic [1:0] m);
        cfg_mode = m; start = 1'b1;
        step();
        start = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) step();
    endtask

    initial begin
        int b0;
        int d0;
        #50000000;
        fails++;
        $display("FAIL watchdog: act hung, exp finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int b0;
        int d0;
        step(); step();
        chk(!busy && !wr_valid && !done && !size_err, "R1 reset outputs", {busy, wr_valid, done, size_err}, 0);
        rst_n = 1'b1;
        step();

        // R2 / R3 / R8: minimum region, always ready
        man_rdy = 1'b1;
        setup(32'h0000_1000, 25'd128, 32'hDEAD_BEEF, 32'h0123_4567, 1000);
        b0 = beats; d0 = dones;
        pulse_start(2'b01);
        chk(busy && wr_valid && wr_addr == 32'h1000, "R2 launch", {busy, wr_valid, wr_addr}, {2'b11, 32'h1000});
        wait_idle();
        chk(done == 1'b1, "R8 done pulse on completion", done, 1);
        step();
        chk(done == 1'b0, "R8 done one cycle", done, 0);
        chk(beats - b0 == 16, "R3 beat count 128B", beats - b0, 16);
        chk(dones - d0 == 1, "R8 done count", dones - d0, 1);
        chk(exp_q.size() == 0, "R3 queue drained", exp_q.size(), 0);

        // R4 / R3: stalling ready, 256 bytes
        man_rdy = 1'b0;
        setup(32'h0004_0000, 25'd256, 32'hA5A5_0F0F, 32'h5A5A_F0F0, 1000);
        b0 = beats;
        pulse_start(2'b01);
        step(); step(); step();
        chk(wr_valid && wr_addr == 32'h0004_0000, "R4 hold while not ready", wr_addr, 32'h0004_0000);
        auto_rdy = 1'b1;
        wait_idle();
        chk(beats - b0 == 32, "R3 beat count 256B", beats - b0, 32);

        // R6: start while busy with new inputs and illegal length
        setup(32'h0008_0000, 25'd512, 32'h1111_2222, 32'h3333_4444, 1000);
        b0 = beats;
        pulse_start(2'b01);
        step(); step(); step(); step();
        dst_base = 32'hFFFF_0000; pat_hi = 32'h0; pat_lo = 32'h0; fill_len = 25'd8;
        pulse_start(2'b01);
        chk(!size_err && busy, "R6 busy start ignored", {size_err, busy}, 2'b01);
        wait_idle();
        chk(beats - b0 == 64, "R6 original run length kept", beats - b0, 64);
        chk(exp_q.size() == 0, "R6 queue drained", exp_q.size(), 0);
        auto_rdy = 1'b0; man_rdy = 1'b1;

        // R5: illegal lengths
        b0 = beats;
        dst_base = 32'h100; fill_len = 25'd120; pulse_start(2'b01);
        chk(size_err && !busy, "R5 too short", {size_err, busy}, 2'b10);
        step(); step();
        chk(!wr_valid && beats == b0, "R5 no write on short", beats - b0, 0);
        fill_len = 25'd132; pulse_start(2'b01);
        chk(size_err && !busy, "R5 unaligned", {size_err, busy}, 2'b10);
        fill_len = 25'd16777224; pulse_start(2'b01);
        chk(size_err && !busy, "R5 too long", {size_err, busy}, 2'b10);
        step(); step();
        chk(beats == b0, "R5 no writes at all", beats - b0, 0);

        // R7: wrong mode ignored, error kept
        fill_len = 25'd128; pulse_start(2'b10);
        chk(!busy && size_err, "R7 wrong mode ignored", {busy, size_err}, 2'b01);

        // R5: good launch clears error
        setup(32'h0000_2000, 25'd128, 32'hCAFE_F00D, 32'h8765_4321, 1000);
        pulse_start(2'b01);
        chk(!size_err && busy, "R5 error cleared by launch", {size_err, busy}, 2'b01);
        wait_idle();
        fill_len = 25'd64; pulse_start(2'b11);
        chk(!busy && !size_err, "R7 wrong mode illegal length", {busy, size_err}, 0);

        // R9: stop while idle
        d0 = dones;
        stop = 1'b1; step(); stop = 1'b0; step();
        chk(!busy && !wr_valid && dones == d0, "R9 idle stop no effect", {busy, wr_valid}, 0);

        // R9: stop while beat stalled
        man_rdy = 1'b0;
        setup(32'h0010_0000, 25'd256, 32'h0BAD_0BAD, 32'hF00D_F00D, 32);
        b0 = beats; d0 = dones;
        pulse_start(2'b01);
        step(); step();
        stop = 1'b1; step(); stop = 1'b0;
        chk(busy && wr_valid, "R9 stop waits for beat", {busy, wr_valid}, 2'b11);
        man_rdy = 1'b1; step();
        man_rdy = 1'b0;
        chk(!busy && beats - b0 == 1, "R9 stop after one beat", beats - b0, 1);
        step();
        chk(dones == d0, "R9 no done on abort", dones - d0, 0);
        exp_q.delete();

        // R9: maximum legal length accepted, then stopped
        setup(32'h4000_0000, 25'd16777216, 32'h7777_8888, 32'h9999_AAAA, 64);
        d0 = dones;
        auto_rdy = 1'b1;
        pulse_start(2'b01);
        chk(busy && !size_err, "R5 maximum length legal", {busy, size_err}, 2'b10);
        for (int i = 0; i < 20; i++) step();
        stop = 1'b1; step(); stop = 1'b0;
        wait_idle();
        step();
        chk(dones == d0 && !busy, "R9 stop long run", dones - d0, 0);
        exp_q.delete();
        auto_rdy = 1'b0;

        // R10: stop on same edge as last beat
        man_rdy = 1'b1;
        setup(32'h0000_8000, 25'd128, 32'h1357_9BDF, 32'h2468_ACE0, 1000);
        b0 = beats; d0 = dones;
        pulse_start(2'b01);
        for (int i = 0; i < 15; i++) step();
        chk(busy && beats - b0 == 15, "R10 fifteen beats before clash", beats - b0, 15);
        stop = 1'b1; step(); stop = 1'b0;
        chk(!busy && done, "R10 done with coincident stop", {busy, done}, 2'b01);
        step();
        chk(beats - b0 == 16 && dones - d0 == 1, "R10 full count", beats - b0, 16);
        chk(exp_q.size() == 0, "R10 queue drained", exp_q.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule